// File: doc/BRIEF.md
# Seconds Counter with Compare Alarm

This block keeps wall-clock time as a 32-bit count of seconds. It advances by one on each cycle where the one-second tick input is high and counting is switched on. Software reaches the block over a small 8-bit register bus with a valid/ready handshake. Reads of the live count go through one group of four byte registers, and new values are loaded through a separate group of four. The load takes effect all at once when the least significant byte is written, so software can set the time without the counter ever holding a half-written value.

A third group of four byte registers holds an alarm value that can be read and written. When the alarm is armed and a counting tick brings the counter to the alarm value, a sticky status bit sets and a one-cycle interrupt pulse is emitted. Software clears the status by writing 0 to it. To set the time, software disarms the alarm, stops counting, writes 0 to load byte 0, writes load bytes 1 to 3, writes the real byte 0, then restarts counting and re-arms the alarm. A read of all four count bytes can be split by a carry. Software detects this by re-reading byte 0 and finding a smaller value.

Bus FSM states: `BUS_IDLE` (waits for `bus_valid`; `BUS_IDLE -> BUS_ACK` on accept, which applies any write and captures read data) and `BUS_ACK` (drives `bus_ready`; `BUS_ACK -> BUS_IDLE` always). Alarm FSM states: `AL_QUIET` (no alarm pending; `AL_QUIET -> AL_FIRE` on a match), `AL_FIRE` (first cycle pending, interrupt high; `AL_FIRE -> AL_HELD` unless cleared, `AL_FIRE -> AL_QUIET` on a clear with no match) and `AL_HELD` (pending, interrupt low; `AL_HELD -> AL_QUIET` on a clear with no match, otherwise stays).

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset, every register reads 0: counting is off, the alarm is disarmed, the status is clear, `bus_ready` is low and `alarm_irq` is low.
- R2: An access is accepted on the first rising edge where `bus_valid` is high. `bus_ready` is then high for exactly one cycle, and `bus_rdata` holds the read data during that cycle.
- R3: Addresses 0x8..0xB read the count as little-endian bytes, with 0x8 the least significant. The value returned is the count at the accepting edge, so a carry between two reads shows as a smaller byte 0. Writes to these addresses have no effect.
- R4: Control register 0x0, bit 7, enables counting. While it is set, the count rises by one on each edge where `sec_tick` is high. Otherwise the count holds.
- R5: The count wraps from 0xFFFFFFFF to 0x00000000 on a counting tick.
- R6: Writes to 0x5, 0x6 and 0x7 only stage bytes 1, 2 and 3 and leave the count unchanged. A write to 0x4 loads {staged 3, staged 2, staged 1, written byte} into the count at that edge, taking priority over a tick. Addresses 0x4..0x7 read as 0.
- R7: Addresses 0xC..0xF hold the alarm value as little-endian bytes (0xC least significant) and read back what was written.
- R8: When bit 1 of register 0x0 is set and a counting tick brings the count to the alarm value, bit 0 of register 0x1 sets at that same edge. It stays set until cleared.
- R9: Writing a byte with bit 0 = 0 to register 0x1 clears the status. Writing bit 0 = 1 leaves it unchanged.
- R10: `alarm_irq` is high for exactly the one cycle after the status goes from 0 to 1. There is no further pulse while the status stays set.
- R11: With bit 1 of register 0x0 clear, a match does not set the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 8 | Read data, valid while `bus_ready` is high |
| sec_tick | input | 1 | One-second tick, one clock wide |
| alarm_irq | output | 1 | Alarm interrupt pulse |

## Verification
A write acts at the edge that accepts it. Its effect can be read back by the next access, and `bus_ready` with the read data appears one cycle after acceptance. Each tick is driven for one edge. The new count, a status set and the interrupt pulse are all due one cycle later, after that edge. The bench drives on falling edges and samples on the falling edge that follows the edge in question. This places every check in the cycle the result is due.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int RTC_DATA_W = 8;
    localparam int RTC_BYTES  = 4;
    localparam int RTC_ADDR_W = 4;
    localparam int RTC_SEL_W  = $clog2(RTC_BYTES);

    typedef logic [RTC_ADDR_W-1:0] rtc_addr_t;

    // register map
    localparam rtc_addr_t CTRL_ADDR = 4'h0;
    localparam rtc_addr_t STAT_ADDR = 4'h1;
    localparam rtc_addr_t LOAD_BASE = 4'h4;
    localparam rtc_addr_t CNT_BASE  = 4'h8;
    localparam rtc_addr_t ALM_BASE  = 4'hC;

    // bit positions
    localparam int RUN_BIT  = 7;
    localparam int ARM_BIT  = 1;
    localparam int STAT_BIT = 0;

    typedef enum logic {BUS_IDLE, BUS_ACK} bus_state_t;
    typedef enum logic [1:0] {AL_QUIET, AL_FIRE, AL_HELD} alm_state_t;

    function automatic logic in_window(rtc_addr_t a, rtc_addr_t base);
        return (a >= base) && ((a - base) < rtc_addr_t'(RTC_BYTES));
    endfunction

    function automatic logic [RTC_SEL_W-1:0] win_sel(rtc_addr_t a, rtc_addr_t base);
        rtc_addr_t off;
        off = a - base;
        return off[RTC_SEL_W-1:0];
    endfunction
endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_pkg::*;
#(
    parameter int DATA_W = RTC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] rd_mux,
    output logic              wr_en,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata
);
    bus_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_valid) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_en     = (state_q == BUS_IDLE) && bus_valid && bus_write;
        bus_ready = (state_q == BUS_ACK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (state_q == BUS_IDLE && bus_valid)
            bus_rdata <= bus_write ? '0 : rd_mux;
    end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_pkg::*;
#(
    parameter int DATA_W = RTC_DATA_W,
    parameter int BYTES  = RTC_BYTES,
    localparam int CNT_W = DATA_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  rtc_addr_t         addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sec_tick,
    input  logic              run_en,
    output logic [CNT_W-1:0]  cnt,
    output logic              load_commit,
    output logic              step
);
    logic [CNT_W-1:DATA_W] stage_q;

    assign load_commit = wr_en && (addr == LOAD_BASE);
    assign step        = sec_tick && run_en && !load_commit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_en) begin
            for (int g = 1; g < BYTES; g++)
                if (addr == rtc_addr_t'(int'(LOAD_BASE) + g))
                    stage_q[g*DATA_W +: DATA_W] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load_commit) cnt <= {stage_q, wdata};
        else if (step)        cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
#(
    parameter int DATA_W = RTC_DATA_W,
    parameter int BYTES  = RTC_BYTES,
    localparam int CNT_W = DATA_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  rtc_addr_t         addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              step,
    input  logic              arm_en,
    output logic [CNT_W-1:0]  alm_val,
    output logic              status,
    output logic              irq,
    output logic              clr_req
);
    alm_state_t state_q, state_d;
    logic       match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_val <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < BYTES; g++)
                if (addr == rtc_addr_t'(int'(ALM_BASE) + g))
                    alm_val[g*DATA_W +: DATA_W] <= wdata;
        end
    end

    // a counting tick that lands the count on the alarm value
    assign match   = arm_en && step && ((cnt + CNT_W'(1)) == alm_val);
    assign clr_req = wr_en && (addr == STAT_ADDR) && !wdata[STAT_BIT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_QUIET: if (match) state_d = AL_FIRE;
            AL_FIRE:  state_d = (clr_req && !match) ? AL_QUIET : AL_HELD;
            AL_HELD:  if (clr_req && !match) state_d = AL_QUIET;
            default:  state_d = AL_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AL_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        status = (state_q != AL_QUIET);
        irq    = (state_q == AL_FIRE);
    end
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
    import rtc_pkg::*;
#(
    parameter int DATA_W = RTC_DATA_W,
    parameter int BYTES  = RTC_BYTES,
    localparam int CNT_W = DATA_W * BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [RTC_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_ready,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  sec_tick,
    output logic                  alarm_irq
);
    logic             wr_en;
    logic             run_en, arm_en;
    logic [CNT_W-1:0] cnt_q, alm_val;
    logic             load_commit, step, alarm_status, clr_req;
    logic [DATA_W-1:0] rd_mux;

    rtc_bus_fsm #(.DATA_W(DATA_W)) bus_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .rd_mux(rd_mux), .wr_en(wr_en), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en <= 1'b0;
            arm_en <= 1'b0;
        end else if (wr_en && bus_addr == CTRL_ADDR) begin
            run_en <= bus_wdata[RUN_BIT];
            arm_en <= bus_wdata[ARM_BIT];
        end
    end

    rtc_sec_counter #(.DATA_W(DATA_W), .BYTES(BYTES)) cnt_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
        .sec_tick(sec_tick), .run_en(run_en), .cnt(cnt_q),
        .load_commit(load_commit), .step(step)
    );

    rtc_alarm_unit #(.DATA_W(DATA_W), .BYTES(BYTES)) alm_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
        .cnt(cnt_q), .step(step), .arm_en(arm_en), .alm_val(alm_val),
        .status(alarm_status), .irq(alarm_irq), .clr_req(clr_req)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == CTRL_ADDR) begin
            rd_mux[RUN_BIT] = run_en;
            rd_mux[ARM_BIT] = arm_en;
        end else if (bus_addr == STAT_ADDR) begin
            rd_mux[STAT_BIT] = alarm_status;
        end else if (in_window(bus_addr, CNT_BASE)) begin
            rd_mux = cnt_q[int'(win_sel(bus_addr, CNT_BASE))*DATA_W +: DATA_W];
        end else if (in_window(bus_addr, ALM_BASE)) begin
            rd_mux = alm_val[int'(win_sel(bus_addr, ALM_BASE))*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_ready,
    input logic [CNT_W-1:0] cnt,
    input logic             step,
    input logic             load_commit,
    input logic             status,
    input logic             clr_req,
    input logic             arm_en,
    input logic             irq
);
    assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    assert_ready_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> $past(bus_valid));
    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_commit) |=> $stable(cnt));
    assert_count_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (&cnt)) |=> (cnt == '0));
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_req) |=> status);
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_with_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status);
    assert_disarmed_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !arm_en) |=> !status);
endmodule

bind rtc_seconds_alarm rtc_alarm_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .cnt(cnt_q), .step(step), .load_commit(load_commit), .status(alarm_status),
    .clr_req(clr_req), .arm_en(arm_en), .irq(alarm_irq)
);

// File: tb/rtc_seconds_alarm_tb_top.sv
module rtc_seconds_alarm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_write = 1'b0, sec_tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_ready, alarm_irq;
    logic [7:0] bus_rdata;
    int total = 0, bad = 0, irq_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_seconds_alarm dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .sec_tick(sec_tick), .alarm_irq(alarm_irq)
    );

    always @(negedge clk) if (rst_n && alarm_irq) irq_seen++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [3:0] a, input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        chk(bus_ready === 1'b1, "R2 ready after accept", 32'(bus_ready), 1);
        q = bus_rdata;
        bus_valid = 1'b0; bus_write = 1'b0;
        @(negedge clk);
        if (bus_ready !== 1'b0) chk(1'b0, "R2 ready one cycle", 32'(bus_ready), 0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] q;
        xfer(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] q);
        xfer(1'b0, a, 8'h00, q);
    endtask

    task automatic rd32(input logic [3:0] base, output logic [31:0] v);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] q;
            rd(base + 4'(i), q);
            v[i*8 +: 8] = q;
        end
    endtask

    task automatic wr32(input logic [3:0] base, input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(base + 4'(i), v[i*8 +: 8]);
    endtask

    task automatic load32(input logic [31:0] v);
        wr(4'h4, 8'h00);
        for (int i = 1; i < 4; i++) wr(4'h4 + 4'(i), v[i*8 +: 8]);
        wr(4'h4, v[7:0]);
    endtask

    task automatic tick(output logic irq_now);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0; irq_now = alarm_irq;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev, base;
        logic [7:0]  q, b0;
        logic        irq_now;
        int          irq0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bus_ready === 1'b0, "R1 ready low", 32'(bus_ready), 0);
        chk(alarm_irq === 1'b0, "R1 irq low", 32'(alarm_irq), 0);
        rd(4'h0, q); chk(q == 8'h00, "R1 ctrl", 32'(q), 0);
        rd(4'h1, q); chk(q == 8'h00, "R1 status", 32'(q), 0);
        rd32(4'h8, v); chk(v == 0, "R1 count", v, 0);
        rd32(4'hC, v); chk(v == 0, "R1 alarm", v, 0);

        // R6 staged load sweep
        prev = 32'h0;
        for (int k = 0; k < 8; k++) begin
            logic [31:0] p;
            p = 32'h9E3779B9 * 32'(k + 1) ^ (32'(k) << 28);
            for (int i = 1; i < 4; i++) wr(4'h4 + 4'(i), p[i*8 +: 8]);
            rd32(4'h8, v); chk(v == prev, "R6 staging leaves count", v, prev);
            wr(4'h4, p[7:0]);
            rd32(4'h8, v); chk(v == p, "R6 commit on byte 0", v, p);
            rd(4'h4 + 4'(k % 4), q); chk(q == 8'h00, "R6 load window reads 0", 32'(q), 0);
            prev = p;
        end

        // R3 count window ignores writes
        wr(4'h8, 8'h55); wr(4'hB, 8'hAA);
        rd32(4'h8, v); chk(v == prev, "R3 write ignored", v, prev);

        // R4 counting gated by enable
        for (int i = 0; i < 3; i++) tick(irq_now);
        rd32(4'h8, v); chk(v == prev, "R4 hold when disabled", v, prev);
        wr(4'h0, 8'h80);
        rd(4'h0, q); chk(q == 8'h80, "R4 ctrl readback", 32'(q), 32'h80);
        for (int i = 0; i < 5; i++) tick(irq_now);
        rd32(4'h8, v); chk(v == prev + 5, "R4 count ticks", v, prev + 5);
        wr(4'h0, 8'h00);
        tick(irq_now);
        rd32(4'h8, v); chk(v == prev + 5, "R4 stop holds", v, prev + 5);

        // R5 wrap
        load32(32'hFFFFFFFE);
        wr(4'h0, 8'h80);
        tick(irq_now);
        rd32(4'h8, v); chk(v == 32'hFFFFFFFF, "R5 before wrap", v, 32'hFFFFFFFF);
        tick(irq_now);
        rd32(4'h8, v); chk(v == 32'h0, "R5 wrap to zero", v, 0);

        // R3 carry split detection
        wr(4'h0, 8'h00);
        load32(32'h000012FF);
        wr(4'h0, 8'h80);
        rd(4'h8, b0); chk(b0 == 8'hFF, "R3 byte0 before carry", 32'(b0), 32'hFF);
        tick(irq_now);
        rd(4'h8, q); chk(q < b0 && q == 8'h00, "R3 byte0 smaller after carry", 32'(q), 0);
        rd(4'h9, q); chk(q == 8'h13, "R3 byte1 carried", 32'(q), 32'h13);

        // R7 alarm window
        wr(4'h0, 8'h00);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            a = 32'hA5C30F1E ^ (32'h11111111 * 32'(k));
            wr32(4'hC, a);
            rd32(4'hC, v); chk(v == a, "R7 alarm readback", v, a);
        end

        // R8 / R10 alarm fire
        base = 32'h00001000;
        load32(base);
        wr32(4'hC, base + 3);
        wr(4'h0, 8'h82);
        irq0 = irq_seen;
        tick(irq_now); tick(irq_now);
        rd(4'h1, q); chk(q == 8'h00, "R8 no status before match", 32'(q), 0);
        tick(irq_now);
        chk(irq_now === 1'b1, "R10 irq after match edge", 32'(irq_now), 1);
        rd(4'h1, q); chk(q == 8'h01, "R8 status set", 32'(q), 1);
        rd32(4'h8, v); chk(v == base + 3, "R8 count at match", v, base + 3);
        tick(irq_now); tick(irq_now);
        rd(4'h1, q); chk(q == 8'h01, "R8 status sticky", 32'(q), 1);
        chk(irq_seen == irq0 + 1, "R10 single pulse", 32'(irq_seen), 32'(irq0 + 1));

        // R9 clear by writing 0
        wr(4'h1, 8'hFF);
        rd(4'h1, q); chk(q == 8'h01, "R9 write 1 no effect", 32'(q), 1);
        wr(4'h1, 8'hFE);
        rd(4'h1, q); chk(q == 8'h00, "R9 write 0 clears", 32'(q), 0);

        // R11 disarmed alarm stays quiet
        wr(4'h0, 8'h80);
        wr32(4'hC, base + 7);
        irq0 = irq_seen;
        tick(irq_now); tick(irq_now);
        rd32(4'h8, v); chk(v == base + 7, "R11 count reached alarm", v, base + 7);
        rd(4'h1, q); chk(q == 8'h00, "R11 no status when disarmed", 32'(q), 0);
        chk(irq_seen == irq0, "R11 no irq when disarmed", 32'(irq_seen), 32'(irq0));

        // R8 match across wrap
        wr(4'h0, 8'h00);
        load32(32'hFFFFFFFF);
        wr32(4'hC, 32'h0);
        wr(4'h0, 8'h82);
        tick(irq_now);
        chk(irq_now === 1'b1, "R10 irq on wrap match", 32'(irq_now), 1);
        rd(4'h1, q); chk(q == 8'h01, "R8 status on wrap match", 32'(q), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule